// File: doc/BRIEF.md
# Immediate-Offset Load/Store Alignment Unit

This unit is the memory-access stage for word, halfword and byte loads and stores whose address is a base register plus a small immediate. A decoded access arrives with its size, direction, base kind (low register or stack pointer), the unscaled immediate field, the base value, the store data and the destination register index. The unit scales the immediate, forms the effective address and checks both the immediate field and the address alignment. It then issues one request on a little-endian 32-bit memory port with byte enables. For loads, it returns the selected lane zero-extended to 32 bits. Condition flags are never touched.

The control is a four-state machine. IDLE accepts a request (`req_ready_o` high). Its transitions are: accept-legal goes to ISSUE, and accept-faulty goes to FAULT. ISSUE holds the memory request until `mem_ready_i`. Its transitions are: store-done goes to IDLE, and load-done goes to RESP. RESP raises the result strobe for one cycle and then returns to IDLE (respond-done). FAULT raises the fault flag for one cycle and then returns to IDLE (fault-done). A faulty access produces no memory request and no result.

Top module: `lsu_align_unit`

## Requirements
- R1: With a low-register base, the effective address is `req_base_i + (req_imm_i[4:0] << size)`, where size code 0 is byte, 1 is halfword and 2 is word.
- R2: With the stack-pointer base (`req_sp_base_i`=1), the offset is `req_imm_i << 2`, which covers 0 to 1020. Only the word size is legal with this base.
- R3: With a low-register base, any set bit in `req_imm_i[7:5]` makes the access illegal. Likewise, a stack-pointer base with a size other than word makes the access illegal. In both cases `fault_illegal_o` pulses for one cycle and no memory request is made.
- R4: A legal access whose effective address is not a multiple of its size in bytes pulses `fault_misalign_o` for one cycle. The request is accepted with no memory request and no result strobe.
- R5: A store drives the source byte on all four lanes (byte), the low halfword on both halves (halfword) or the whole word (word). Byte lane n is bits [8n+7:8n] at address offset n. The byte enable is one-hot at `addr[1:0]` for a byte store, 4'b0011 or 4'b1100 by `addr[1]` for a halfword store, and 4'b1111 for a word store.
- R6: A load returns the byte at lane `addr[1:0]`, the halfword at `addr[1]`, or the whole word, zero-extended to 32 bits.
- R7: `req_ready_o` is high only in IDLE. `mem_valid_o` stays high with a stable address and byte enable until `mem_ready_i` is sampled high.
- R8: One cycle after a load's memory handshake, `res_valid_o` is high for exactly one cycle with `res_data_o` and `res_rd_o` (the request's register index). Stores give no result strobe.
- R9: After reset the unit is in IDLE: `req_ready_o`=1, and `mem_valid_o`, `res_valid_o` and both fault flags are 0.
- R10: Size code 3 is illegal for any base and raises `fault_illegal_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| req_load_i | input | 1 | 1 = load, 0 = store |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_sp_base_i | input | 1 | Base is the stack pointer |
| req_imm_i | input | 8 | Unscaled immediate field |
| req_base_i | input | 32 | Base register value |
| req_wdata_i | input | 32 | Store source register value |
| req_rd_i | input | 3 | Destination register index (R0 to R7) |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts request / load data valid |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Effective byte address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Lane-replicated store data |
| mem_rdata_i | input | 32 | Load word, valid with mem_ready_i |
| res_valid_o | output | 1 | Load result strobe |
| res_data_o | output | 32 | Zero-extended load result |
| res_rd_o | output | 3 | Destination register of result |
| fault_misalign_o | output | 1 | Misalignment fault pulse |
| fault_illegal_o | output | 1 | Illegal immediate/size fault pulse |

## Verification
The properties assume that the memory side answers a load with valid `mem_rdata_i` in the same cycle that `mem_ready_i` is high. They also assume that `mem_ready_i` may be low for any number of cycles without the unit dropping its request. The stimulus drives requests only at falling edges, and only while `req_ready_o` is high. It holds a request for exactly one accepting edge and backs the memory port with a bench-side array that responds in the accepting cycle. The stimulus also stalls `mem_ready_i` once, to exercise the hold rule.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_RESP,
        ST_FAULT
    } lsu_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int IMM_W     = 8,
    parameter int LOW_IMM_W = 5
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [1:0]        size_i,
    input  logic              sp_base_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              illegal_o,
    output logic              misalign_o
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset    = '0;
        illegal_o = 1'b0;
        if (sp_base_i) begin
            offset    = ADDR_W'(imm_i) << 2;
            illegal_o = (size_i != SZ_WORD);
        end else begin
            offset    = ADDR_W'(imm_i[LOW_IMM_W-1:0]) << size_i;
            illegal_o = (imm_i[IMM_W-1:LOW_IMM_W] != '0) || (size_i == 2'd3);
        end
    end

    assign addr_o = base_i + offset;

    always_comb begin
        misalign_o = 1'b0;
        if (!illegal_o) begin
            unique case (size_i)
                SZ_HALF: misalign_o = addr_o[0];
                SZ_WORD: misalign_o = (addr_o[1:0] != 2'b00);
                default: misalign_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES   = DATA_W / 8,
    localparam int LANE_AW = $clog2(LANES)
) (
    input  logic [1:0]         size_i,
    input  logic [LANE_AW-1:0] addr_lo_i,
    input  logic [DATA_W-1:0]  src_i,
    output logic [LANES-1:0]   be_o,
    output logic [DATA_W-1:0]  data_o
);
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        always_comb begin
            unique case (size_i)
                SZ_BYTE: begin
                    be_o[n]          = (addr_lo_i == LANE_AW'(n));
                    data_o[8*n +: 8] = src_i[7:0];
                end
                SZ_HALF: begin
                    be_o[n]          = ((n / 2) == int'(addr_lo_i[LANE_AW-1:1]));
                    data_o[8*n +: 8] = src_i[8*(n%2) +: 8];
                end
                default: begin
                    be_o[n]          = 1'b1;
                    data_o[8*n +: 8] = src_i[8*n +: 8];
                end
            endcase
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES   = DATA_W / 8,
    localparam int LANE_AW = $clog2(LANES)
) (
    input  logic [1:0]         size_i,
    input  logic [LANE_AW-1:0] addr_lo_i,
    input  logic [DATA_W-1:0]  word_i,
    output logic [DATA_W-1:0]  data_o
);
    logic [DATA_W-1:0] byte_sh;
    logic [DATA_W-1:0] half_sh;

    assign byte_sh = word_i >> {addr_lo_i, 3'b000};
    assign half_sh = word_i >> {addr_lo_i[LANE_AW-1:1], 4'b0000};

    always_comb begin
        unique case (size_i)
            SZ_BYTE: data_o = DATA_W'(byte_sh[7:0]);
            SZ_HALF: data_o = DATA_W'(half_sh[15:0]);
            default: data_o = word_i;
        endcase
    end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int IMM_W     = 8,
    parameter int LOW_IMM_W = 5,
    parameter int RIDX_W    = 3,
    localparam int LANES    = DATA_W / 8,
    localparam int LANE_AW  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_load_i,
    input  logic [1:0]        req_size_i,
    input  logic              req_sp_base_i,
    input  logic [IMM_W-1:0]  req_imm_i,
    input  logic [ADDR_W-1:0] req_base_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [RIDX_W-1:0] req_rd_i,
    output logic              mem_valid_o,
    input  logic              mem_ready_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [LANES-1:0]  mem_be_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              res_valid_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic [RIDX_W-1:0] res_rd_o,
    output logic              fault_misalign_o,
    output logic              fault_illegal_o
);
    lsu_state_e state_q, state_d;

    logic [ADDR_W-1:0] ag_addr;
    logic              ag_ill, ag_mis;
    logic [LANES-1:0]  sl_be;
    logic [DATA_W-1:0] sl_data;
    logic [DATA_W-1:0] lx_data;

    logic [ADDR_W-1:0] q_addr;
    logic [LANES-1:0]  q_be;
    logic [DATA_W-1:0] q_wdata;
    logic [1:0]        q_size;
    logic              q_load, q_mis, q_ill;
    logic [RIDX_W-1:0] q_rd;
    logic [DATA_W-1:0] q_res;

    logic accept, mem_fire;

    lsu_addr_gen #(
        .ADDR_W   (ADDR_W),
        .IMM_W    (IMM_W),
        .LOW_IMM_W(LOW_IMM_W)
    ) addr_gen_i (
        .base_i    (req_base_i),
        .imm_i     (req_imm_i),
        .size_i    (req_size_i),
        .sp_base_i (req_sp_base_i),
        .addr_o    (ag_addr),
        .illegal_o (ag_ill),
        .misalign_o(ag_mis)
    );

    lsu_store_lanes #(.DATA_W(DATA_W)) store_lanes_i (
        .size_i   (req_size_i),
        .addr_lo_i(ag_addr[LANE_AW-1:0]),
        .src_i    (req_wdata_i),
        .be_o     (sl_be),
        .data_o   (sl_data)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) load_extract_i (
        .size_i   (q_size),
        .addr_lo_i(q_addr[LANE_AW-1:0]),
        .word_i   (mem_rdata_i),
        .data_o   (lx_data)
    );

    assign accept   = (state_q == ST_IDLE) && req_valid_i;
    assign mem_fire = (state_q == ST_ISSUE) && mem_ready_i;

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = (ag_ill || ag_mis) ? ST_FAULT : ST_ISSUE;
            ST_ISSUE: if (mem_ready_i) state_d = q_load ? ST_RESP : ST_IDLE;
            ST_RESP:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // access capture and load result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_be    <= '0;
            q_wdata <= '0;
            q_size  <= '0;
            q_load  <= 1'b0;
            q_mis   <= 1'b0;
            q_ill   <= 1'b0;
            q_rd    <= '0;
            q_res   <= '0;
        end else begin
            if (accept) begin
                q_addr  <= ag_addr;
                q_be    <= sl_be;
                q_wdata <= sl_data;
                q_size  <= req_size_i;
                q_load  <= req_load_i;
                q_mis   <= ag_mis;
                q_ill   <= ag_ill;
                q_rd    <= req_rd_i;
            end
            if (mem_fire && q_load) q_res <= lx_data;
        end
    end

    // outputs
    always_comb begin
        req_ready_o      = (state_q == ST_IDLE);
        mem_valid_o      = (state_q == ST_ISSUE);
        res_valid_o      = (state_q == ST_RESP);
        fault_misalign_o = (state_q == ST_FAULT) && q_mis;
        fault_illegal_o  = (state_q == ST_FAULT) && q_ill;
        mem_we_o         = mem_valid_o && !q_load;
        mem_addr_o       = q_addr;
        mem_be_o         = q_be;
        mem_wdata_o      = q_wdata;
        res_data_o       = q_res;
        res_rd_o         = q_rd;
    end
endmodule

// File: rtl/lsu_align_unit_chk.sv
module lsu_align_unit_chk #(
    parameter int ADDR_W = 32,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready_o,
    input logic              mem_valid_o,
    input logic              mem_ready_i,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [LANES-1:0]  mem_be_o,
    input logic              res_valid_o,
    input logic              fault_misalign_o,
    input logic              fault_illegal_o
);
    p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_be_o)));

    p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (!mem_valid_o && !res_valid_o));

    p_mis_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_misalign_o |=> !fault_misalign_o);

    p_ill_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fault_illegal_o |=> !fault_illegal_o);

    p_fault_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_misalign_o || fault_illegal_o) |-> (!mem_valid_o && !res_valid_o));

    p_res_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    p_res_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(mem_valid_o && mem_ready_i && !mem_we_o));

    p_be_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2
                         || $countones(mem_be_o) == LANES));

    p_full_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && mem_be_o == '1) |-> (mem_addr_o[1:0] == 2'b00));
endmodule

bind lsu_align_unit lsu_align_unit_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) chk_i (.*);

// File: tb/lsu_align_unit_tb.sv
module lsu_align_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_load = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_sp = 1'b0;
    logic [7:0]  req_imm = 8'd0;
    logic [31:0] req_base = 32'd0;
    logic [31:0] req_wdata = 32'd0;
    logic [2:0]  req_rd = 3'd0;
    logic        mem_valid, mem_we;
    logic        mem_ready = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        res_valid;
    logic [31:0] res_data;
    logic [2:0]  res_rd;
    logic        f_mis, f_ill;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    lsu_align_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_load_i(req_load), .req_size_i(req_size), .req_sp_base_i(req_sp),
        .req_imm_i(req_imm), .req_base_i(req_base), .req_wdata_i(req_wdata),
        .req_rd_i(req_rd),
        .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata),
        .res_valid_o(res_valid), .res_data_o(res_data), .res_rd_o(res_rd),
        .fault_misalign_o(f_mis), .fault_illegal_o(f_ill)
    );

    // bench memory: 64 words, indexed by address bits [7:2]
    logic [31:0] mem [64];
    initial for (int i = 0; i < 64; i++) mem[i] = 32'hF1E2D3C4;
    assign mem_rdata = mem[mem_addr[7:2]];
    always @(posedge clk) begin
        if (mem_valid && mem_ready && mem_we)
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end

    typedef struct packed {
        logic        ld;
        logic [1:0]  size;
        logic        sp;
        logic [7:0]  imm;
        logic [31:0] base;
        logic [31:0] wdata;
        logic [2:0]  rd;
        logic [31:0] addr;
        logic [3:0]  be;
        logic        mis;
        logic        ill;
        logic [31:0] rdata;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0,2'd2,1'b0,8'h05,32'h100,32'h11223344,3'd0,32'h114,4'hF,1'b0,1'b0,32'h0},        // R1 word store
        '{1'b0,2'd0,1'b0,8'h03,32'h120,32'h123456AB,3'd0,32'h123,4'h8,1'b0,1'b0,32'h0},        // R5 byte store lane 3
        '{1'b0,2'd1,1'b0,8'h01,32'h130,32'hDEAD5566,3'd0,32'h132,4'hC,1'b0,1'b0,32'h0},        // R5 upper half store
        '{1'b0,2'd2,1'b1,8'h40,32'h200,32'hCAFEF00D,3'd0,32'h300,4'hF,1'b0,1'b0,32'h0},        // R2 stack base store
        '{1'b1,2'd2,1'b0,8'h05,32'h100,32'h0,3'd1,32'h114,4'hF,1'b0,1'b0,32'h11223344},        // R6 word load
        '{1'b1,2'd0,1'b0,8'h03,32'h120,32'h0,3'd2,32'h123,4'h8,1'b0,1'b0,32'h000000AB},        // R6 byte lane 3
        '{1'b1,2'd0,1'b0,8'h01,32'h120,32'h0,3'd3,32'h121,4'h2,1'b0,1'b0,32'h000000D3},        // R6 byte lane 1
        '{1'b1,2'd1,1'b0,8'h01,32'h130,32'h0,3'd4,32'h132,4'hC,1'b0,1'b0,32'h00005566},        // R6 upper half
        '{1'b1,2'd1,1'b0,8'h00,32'h130,32'h0,3'd5,32'h130,4'h3,1'b0,1'b0,32'h0000D3C4},        // R6 lower half
        '{1'b1,2'd2,1'b1,8'hFF,32'h010,32'h0,3'd6,32'h40C,4'hF,1'b0,1'b0,32'hF1E2D3C4},        // R2 offset 1020
        '{1'b1,2'd2,1'b1,8'h40,32'h200,32'h0,3'd7,32'h300,4'hF,1'b0,1'b0,32'hCAFEF00D},        // R2 stack load
        '{1'b1,2'd2,1'b0,8'h01,32'h101,32'h0,3'd0,32'h0,4'h0,1'b1,1'b0,32'h0},                 // R4 word misaligned
        '{1'b0,2'd1,1'b0,8'h00,32'h103,32'h1,3'd0,32'h0,4'h0,1'b1,1'b0,32'h0},                 // R4 half misaligned
        '{1'b1,2'd0,1'b1,8'h02,32'h200,32'h0,3'd0,32'h0,4'h0,1'b0,1'b1,32'h0},                 // R3 stack byte
        '{1'b1,2'd2,1'b0,8'h20,32'h100,32'h0,3'd0,32'h0,4'h0,1'b0,1'b1,32'h0},                 // R3 wide field
        '{1'b1,2'd0,1'b0,8'h1F,32'h100,32'h0,3'd2,32'h11F,4'h8,1'b0,1'b0,32'h000000F1},        // R1 byte offset 31
        '{1'b1,2'd1,1'b0,8'h1F,32'h100,32'h0,3'd3,32'h13E,4'hC,1'b0,1'b0,32'h0000F1E2},        // R1 half offset 62
        '{1'b1,2'd3,1'b0,8'h00,32'h100,32'h0,3'd0,32'h0,4'h0,1'b0,1'b1,32'h0}                  // R10 size code 3
    };

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lanes_of(input logic [1:0] sz, input logic [31:0] w);
        if (sz == 2'd0) return {4{w[7:0]}};
        if (sz == 2'd1) return {2{w[15:0]}};
        return w;
    endfunction

    task automatic apply(input vec_t v);
        @(negedge clk);
        req_valid = 1'b1; req_load = v.ld; req_size = v.size; req_sp = v.sp;
        req_imm = v.imm; req_base = v.base; req_wdata = v.wdata; req_rd = v.rd;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R7 busy", 32'(req_ready), 32'h0);
        if (v.mis || v.ill) begin
            check(f_mis == v.mis, "R4 misalign flag", 32'(f_mis), 32'(v.mis));
            check(f_ill == v.ill, "R3 illegal flag", 32'(f_ill), 32'(v.ill));
            check(mem_valid == 1'b0, "R4 no request", 32'(mem_valid), 32'h0);
            @(negedge clk);
            check(!f_mis && !f_ill, "R4 pulse ends", {30'd0, f_mis, f_ill}, 32'h0);
            check(res_valid == 1'b0, "R4 no result", 32'(res_valid), 32'h0);
        end else begin
            check(mem_valid == 1'b1, "R7 request", 32'(mem_valid), 32'h1);
            check(mem_addr == v.addr, "R1 address", mem_addr, v.addr);
            check(mem_be == v.be, "R5 byte enable", 32'(mem_be), 32'(v.be));
            check(mem_we == !v.ld, "R5 write", 32'(mem_we), 32'(!v.ld));
            if (!v.ld)
                check(mem_wdata == lanes_of(v.size, v.wdata), "R5 lane data",
                      mem_wdata, lanes_of(v.size, v.wdata));
            @(negedge clk);
            check(res_valid == v.ld, "R8 strobe", 32'(res_valid), 32'(v.ld));
            if (v.ld) begin
                check(res_data == v.rdata, "R6 load data", res_data, v.rdata);
                check(res_rd == v.rd, "R8 dest index", 32'(res_rd), 32'(v.rd));
            end
        end
        @(negedge clk);
        check(req_ready == 1'b1 && res_valid == 1'b0, "R8 back to idle",
              {30'd0, req_ready, res_valid}, 32'h2);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R9 ready in reset", 32'(req_ready), 32'h1);
        check(!mem_valid && !res_valid && !f_mis && !f_ill, "R9 quiet in reset",
              {28'd0, mem_valid, res_valid, f_mis, f_ill}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && !mem_valid, "R9 idle after reset",
              {30'd0, req_ready, mem_valid}, 32'h2);

        for (int i = 0; i < NV; i++) apply(VEC[i]);

        // R7 stall: request must hold until memory is ready
        @(negedge clk);
        mem_ready = 1'b0;
        req_valid = 1'b1; req_load = 1'b1; req_size = 2'd2; req_sp = 1'b0;
        req_imm = 8'h05; req_base = 32'h100; req_rd = 3'd5;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(mem_valid && mem_addr == 32'h114, "R7 held request", mem_addr, 32'h114);
            check(req_ready == 1'b0 && res_valid == 1'b0, "R7 no early result",
                  {30'd0, req_ready, res_valid}, 32'h0);
        end
        mem_ready = 1'b1;
        @(negedge clk);
        check(res_valid == 1'b1 && res_data == 32'h11223344, "R8 result after stall",
              res_data, 32'h11223344);
        check(res_rd == 3'd5, "R8 stall dest", 32'(res_rd), 32'h5);
        @(negedge clk);
        check(res_valid == 1'b0, "R8 single cycle", 32'(res_valid), 32'h0);

        // R4 misaligned half store must leave memory unchanged (word index 0 = 0x300 data)
        apply('{1'b0,2'd1,1'b0,8'h00,32'h301,32'h0000BEEF,3'd0,32'h0,4'h0,1'b1,1'b0,32'h0});
        apply('{1'b1,2'd2,1'b1,8'h40,32'h200,32'h0,3'd1,32'h300,4'hF,1'b0,1'b0,32'hCAFEF00D});

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule